// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block is the trap-entry half of a system-control coprocessor for a 32-bit pipelined processor that has branch delay slots. The pipeline raises a synchronous exception request (breakpoint, system call, coprocessor unusable, or a translation fault that carries its own code, vector and faulting address). The block holds that request, together with the PC and delay-slot flag of the offending instruction, until the pipeline signals a commit point. At that commit point it updates the control registers and pulses a redirect to the handler vector. Level-sensitive interrupt lines are also sampled at commit points. They are taken only when the status register enables them and a pending line is unmasked.

Six control registers are kept here: Status, Cause, EPC, BadVAddr, Context and EntryHi. Software reads and writes them through a small register port. The controller is a two-state machine. In IDLE, a request moves it to HELD (the capture transition), and a commit point with a qualified interrupt takes the interrupt without leaving IDLE (the interrupt transition). In HELD, a commit point performs the entry and returns to IDLE (the commit transition). A request that arrives in HELD is dropped and flagged (the duplicate transition, which stays in HELD).

Top module: `exc_entry_ctl`

## Requirements
- R1: On every entry, Status bit 1 (EXL) becomes 1. EPC receives the PC of the trapping instruction when that instruction is not in a delay slot, and Cause bit 31 (BD) becomes 0.
- R2: When the trapping instruction is in a delay slot, Cause bit 31 becomes 1 and EPC receives that PC minus 4.
- R3: Entry rewrites only the Cause exception-code field (bits 6..2). The coprocessor field (bits 29..28) is rewritten only by a coprocessor-unusable entry. The software interrupt bits (9..8) are left unchanged.
- R4: An interrupt is taken at a commit point only when Status bits 2..0 (ERL, EXL, IE) equal 001. The entry code is 0.
- R5: An interrupt also needs a nonzero AND of the Status mask bits 15..8 and the Cause pending bits 15..8. Bits 15..10 are the live hardware lines and bits 9..8 are the software bits.
- R6: A translation fault loads BadVAddr with the faulting address.
- R7: A translation fault keeps Context bits 31..23 and sets bits 22..0 to the faulting address bits 31..13 shifted left by 4.
- R8: A translation fault keeps EntryHi bits 12..0 and sets bits 31..13 to the faulting address bits 31..13.
- R9: A coprocessor-unusable entry writes the request's coprocessor number into Cause bits 29..28, replacing the old value. It uses code 11.
- R10: Breakpoint (code 9), system call (code 8), coprocessor unusable and interrupt entries redirect to 0x80000180. A translation fault redirects to its own vector and uses its own code (2 or 3).
- R11: A request is captured with its PC and delay flag. The entry happens only at the next commit point and uses the captured values. The redirect strobe is high for exactly the one cycle after that commit edge.
- R12: A request that arrives in IDLE wins over a qualified interrupt in the same cycle. No interrupt is taken in that cycle.
- R13: A request that arrives while one is held raises the duplicate flag in the following cycle and is discarded.
- R14: Register port addresses: 0 Status (all bits writable), 1 Cause (only bits 9..8 writable), 2 EPC, 3 BadVAddr (read-only), 4 Context (only bits 31..23 writable), 5 EntryHi. All registers reset to 0, and an entry takes precedence over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_kind | input | 2 | 0 breakpoint, 1 system call, 2 coprocessor unusable, 3 translation fault |
| exc_cop | input | 2 | Coprocessor number for a coprocessor-unusable request |
| tlb_code | input | 5 | Exception code of a translation fault |
| tlb_vec | input | 32 | Handler vector of a translation fault |
| tlb_vaddr | input | 32 | Faulting virtual address |
| pc_in | input | 32 | PC of the current instruction |
| pc_in_dslot | input | 1 | Current instruction sits in a delay slot |
| commit_pt | input | 1 | Commit point: entry may happen now |
| irq_in | input | IRQ_W | Level-sensitive hardware interrupt lines |
| cp_we | input | 1 | Register write strobe |
| cp_addr | input | 3 | Register address |
| cp_wdata | input | 32 | Register write data |
| cp_rdata | output | 32 | Register read data, combinational from cp_addr |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | Redirect target |
| dup_req_err | output | 1 | A second request arrived while one was held |

## Verification
The assertions check on every cycle that each redirect sets EXL, follows a commit point and lasts one cycle. They also check that an interrupt-coded entry was gated by Status bits 001, that general-code entries use the general vector, and that a duplicate flag follows a request. Other behaviours need a scenario to show them. These are the field merging into Context and EntryHi, the delay-slot EPC adjustment, the use of the captured PC after pc_in has moved on, the coprocessor field replacement, the mask-by-mask interrupt refusals, and the priority of a request over an interrupt in the same cycle. The bench's cycle-level reference model and its directed register reads cover these.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int SOFT_W = 2;

    typedef enum logic [1:0] {
        K_BREAK   = 2'd0,
        K_SYSCALL = 2'd1,
        K_COPU    = 2'd2,
        K_TLB     = 2'd3
    } exc_kind_e;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_HELD = 1'b1
    } entry_state_e;

    localparam logic [4:0] CODE_INT  = 5'd0;
    localparam logic [4:0] CODE_SYS  = 5'd8;
    localparam logic [4:0] CODE_BRK  = 5'd9;
    localparam logic [4:0] CODE_COPU = 5'd11;

    localparam logic [2:0] RA_STATUS  = 3'd0;
    localparam logic [2:0] RA_CAUSE   = 3'd1;
    localparam logic [2:0] RA_EPC     = 3'd2;
    localparam logic [2:0] RA_BADVA   = 3'd3;
    localparam logic [2:0] RA_CONTEXT = 3'd4;
    localparam logic [2:0] RA_ENTRYHI = 3'd5;

    typedef struct packed {
        logic [31:0] pc;
        logic        dly;
        logic [4:0]  code;
        logic [31:0] vec;
        logic        tlb;
        logic        copu;
        logic [1:0]  cop;
        logic [31:0] vaddr;
    } exc_rec_t;

endpackage

// File: rtl/exc_req_latch.sv
module exc_req_latch
    import exc_entry_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  logic     clr,
    input  exc_rec_t din,
    output exc_rec_t q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end else if (clr) begin
            q <= '0;
        end
    end

endmodule

// File: rtl/exc_irq_qual.sv
module exc_irq_qual #(
    parameter int IP_W = 8
) (
    input  logic [31:0]     status,
    input  logic [IP_W-1:0] pending,
    output logic            take_ok
);

    logic enabled;
    logic unmasked;

    always_comb begin
        enabled  = (status[2:0] == 3'b001);
        unmasked = |(status[8 +: IP_W] & pending);
        take_ok  = enabled && unmasked;
    end

endmodule

// File: rtl/exc_cp0_file.sv
module exc_cp0_file
    import exc_entry_pkg::*;
#(
    parameter int IRQ_W = 6,
    localparam int IP_W = IRQ_W + SOFT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ent,
    input  logic [31:0]     ent_epc,
    input  logic            ent_bd,
    input  logic [4:0]      ent_code,
    input  logic            ent_copu,
    input  logic [1:0]      ent_cop,
    input  logic            ent_tlb,
    input  logic [31:0]     ent_vaddr,
    input  logic            sw_we,
    input  logic [2:0]      sw_addr,
    input  logic [31:0]     sw_wdata,
    input  logic [IRQ_W-1:0] hw_irq,
    output logic [31:0]     status_q,
    output logic [31:0]     cause_rd,
    output logic [IP_W-1:0] pending,
    output logic [31:0]     rdata
);

    logic              bd_q;
    logic [1:0]        ce_q;
    logic [4:0]        code_q;
    logic [SOFT_W-1:0] soft_q;
    logic [31:0]       epc_q;
    logic [31:0]       bva_q;
    logic [31:0]       ctx_q;
    logic [31:0]       ehi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            bd_q     <= 1'b0;
            ce_q     <= '0;
            code_q   <= '0;
            soft_q   <= '0;
            epc_q    <= '0;
            bva_q    <= '0;
            ctx_q    <= '0;
            ehi_q    <= '0;
        end else if (ent) begin
            status_q[1] <= 1'b1;
            epc_q       <= ent_epc;
            bd_q        <= ent_bd;
            code_q      <= ent_code;
            if (ent_copu) begin
                ce_q <= ent_cop;
            end
            if (ent_tlb) begin
                bva_q         <= ent_vaddr;
                ctx_q[22:0]   <= {ent_vaddr[31:13], 4'b0000};
                ehi_q[31:13]  <= ent_vaddr[31:13];
            end
        end else if (sw_we) begin
            case (sw_addr)
                RA_STATUS:  status_q      <= sw_wdata;
                RA_CAUSE:   soft_q        <= sw_wdata[8 +: SOFT_W];
                RA_EPC:     epc_q         <= sw_wdata;
                RA_CONTEXT: ctx_q[31:23]  <= sw_wdata[31:23];
                RA_ENTRYHI: ehi_q         <= sw_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        pending          = {hw_irq, soft_q};
        cause_rd         = '0;
        cause_rd[31]     = bd_q;
        cause_rd[29:28]  = ce_q;
        cause_rd[8 +: IP_W] = pending;
        cause_rd[6:2]    = code_q;
    end

    always_comb begin
        case (sw_addr)
            RA_STATUS:  rdata = status_q;
            RA_CAUSE:   rdata = cause_rd;
            RA_EPC:     rdata = epc_q;
            RA_BADVA:   rdata = bva_q;
            RA_CONTEXT: rdata = ctx_q;
            RA_ENTRYHI: rdata = ehi_q;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/exc_entry_ctl.sv
module exc_entry_ctl
    import exc_entry_pkg::*;
#(
    parameter int          IRQ_W   = 6,
    parameter logic [31:0] GEN_VEC = 32'h8000_0180
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_req,
    input  logic [1:0]       exc_kind,
    input  logic [1:0]       exc_cop,
    input  logic [4:0]       tlb_code,
    input  logic [31:0]      tlb_vec,
    input  logic [31:0]      tlb_vaddr,
    input  logic [31:0]      pc_in,
    input  logic             pc_in_dslot,
    input  logic             commit_pt,
    input  logic [IRQ_W-1:0] irq_in,
    input  logic             cp_we,
    input  logic [2:0]       cp_addr,
    input  logic [31:0]      cp_wdata,
    output logic [31:0]      cp_rdata,
    output logic             redir_valid,
    output logic [31:0]      redir_pc,
    output logic             dup_req_err
);

    localparam int IP_W = IRQ_W + SOFT_W;

    entry_state_e    state_q, state_d;
    exc_rec_t        new_rec, held_rec, ent_rec;
    logic            irq_ok;
    logic            take_exc, take_irq, enter;
    logic            cap;
    logic [31:0]     ent_epc;
    logic [31:0]     status_q;
    logic [31:0]     cause_rd;
    logic [IP_W-1:0] pending;

    // Decode the incoming request into a record
    always_comb begin
        new_rec       = '0;
        new_rec.pc    = pc_in;
        new_rec.dly   = pc_in_dslot;
        new_rec.vec   = GEN_VEC;
        new_rec.vaddr = tlb_vaddr;
        new_rec.cop   = exc_cop;
        unique case (exc_kind)
            K_BREAK:   new_rec.code = CODE_BRK;
            K_SYSCALL: new_rec.code = CODE_SYS;
            K_COPU: begin
                new_rec.code = CODE_COPU;
                new_rec.copu = 1'b1;
            end
            K_TLB: begin
                new_rec.code = tlb_code;
                new_rec.vec  = tlb_vec;
                new_rec.tlb  = 1'b1;
            end
        endcase
    end

    // Next-state and entry decisions
    always_comb begin
        state_d  = state_q;
        take_exc = 1'b0;
        take_irq = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (exc_req) begin
                    state_d = S_HELD;
                end else if (commit_pt && irq_ok) begin
                    take_irq = 1'b1;
                end
            end
            S_HELD: begin
                if (commit_pt) begin
                    take_exc = 1'b1;
                    state_d  = S_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cap   = (state_q == S_IDLE) && exc_req;
        enter = take_exc || take_irq;
        if (take_exc) begin
            ent_rec = held_rec;
        end else begin
            ent_rec      = '0;
            ent_rec.pc   = pc_in;
            ent_rec.dly  = pc_in_dslot;
            ent_rec.code = CODE_INT;
            ent_rec.vec  = GEN_VEC;
        end
        ent_epc = ent_rec.dly ? (ent_rec.pc - 32'd4) : ent_rec.pc;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_pc    <= '0;
            dup_req_err <= 1'b0;
        end else begin
            redir_valid <= enter;
            if (enter) begin
                redir_pc <= ent_rec.vec;
            end
            dup_req_err <= (state_q == S_HELD) && exc_req;
        end
    end

    exc_req_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cap),
        .clr   (take_exc),
        .din   (new_rec),
        .q     (held_rec)
    );

    exc_irq_qual #(.IP_W(IP_W)) u_qual (
        .status  (status_q),
        .pending (pending),
        .take_ok (irq_ok)
    );

    exc_cp0_file #(.IRQ_W(IRQ_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent       (enter),
        .ent_epc   (ent_epc),
        .ent_bd    (ent_rec.dly),
        .ent_code  (ent_rec.code),
        .ent_copu  (ent_rec.copu),
        .ent_cop   (ent_rec.cop),
        .ent_tlb   (ent_rec.tlb),
        .ent_vaddr (ent_rec.vaddr),
        .sw_we     (cp_we),
        .sw_addr   (cp_addr),
        .sw_wdata  (cp_wdata),
        .hw_irq    (irq_in),
        .status_q  (status_q),
        .cause_rd  (cause_rd),
        .pending   (pending),
        .rdata     (cp_rdata)
    );

endmodule

// File: rtl/exc_entry_ctl_chk.sv
module exc_entry_ctl_chk #(
    parameter logic [31:0] GEN_VEC = 32'h8000_0180
) (
    input logic        clk,
    input logic        rst_n,
    input logic        redir_valid,
    input logic [31:0] redir_pc,
    input logic        dup_req_err,
    input logic        exc_req,
    input logic        commit_pt,
    input logic [2:0]  st_low,
    input logic [4:0]  cause_code
);

    // R1: every redirect leaves EXL set
    p_exl_on_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> st_low[1]);

    // R4: an interrupt-coded entry was enabled by Status bits 001
    p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && cause_code == 5'd0) |-> ($past(st_low) == 3'b001));

    // R10: general codes go to the general vector
    p_gen_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && (cause_code == 5'd0 || cause_code == 5'd8 ||
                         cause_code == 5'd9 || cause_code == 5'd11))
        |-> (redir_pc == GEN_VEC));

    // R11: redirect follows a commit point and lasts one cycle
    p_redir_after_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> $past(commit_pt));

    p_redir_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !redir_valid);

    // R13: duplicate flag only after a request
    p_dup_after_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        dup_req_err |-> $past(exc_req));

endmodule

bind exc_entry_ctl exc_entry_ctl_chk #(.GEN_VEC(GEN_VEC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .dup_req_err (dup_req_err),
    .exc_req     (exc_req),
    .commit_pt   (commit_pt),
    .st_low      (status_q[2:0]),
    .cause_code  (cause_rd[6:2])
);

// File: tb/exc_entry_ctl_test.sv
`timescale 1ns/1ps
module exc_entry_ctl_test;

    localparam logic [31:0] GV = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [1:0]  exc_kind = '0;
    logic [1:0]  exc_cop = '0;
    logic [4:0]  tlb_code = '0;
    logic [31:0] tlb_vec = '0;
    logic [31:0] tlb_vaddr = '0;
    logic [31:0] pc_in = '0;
    logic        pc_in_dslot = 1'b0;
    logic        commit_pt = 1'b0;
    logic [5:0]  irq_in = '0;
    logic        cp_we = 1'b0;
    logic [2:0]  cp_addr = '0;
    logic [31:0] cp_wdata = '0;
    logic [31:0] cp_rdata;
    logic        redir_valid;
    logic [31:0] redir_pc;
    logic        dup_req_err;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_tag = "R14";

    always #5 clk = ~clk;

    exc_entry_ctl uut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_kind(exc_kind),
        .exc_cop(exc_cop), .tlb_code(tlb_code), .tlb_vec(tlb_vec),
        .tlb_vaddr(tlb_vaddr), .pc_in(pc_in), .pc_in_dslot(pc_in_dslot),
        .commit_pt(commit_pt), .irq_in(irq_in), .cp_we(cp_we),
        .cp_addr(cp_addr), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .dup_req_err(dup_req_err)
    );

    // Behavioural reference model
    logic [31:0] m_st, m_epc, m_bva, m_ctx, m_ehi, m_rpc;
    logic        m_bd, m_rv, m_dup, m_held;
    logic [1:0]  m_ce, m_soft;
    logic [4:0]  m_code;
    logic [31:0] l_pc, l_vec, l_va;
    logic        l_dly, l_tlb, l_copu;
    logic [4:0]  l_code;
    logic [1:0]  l_cop;

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_st;
            3'd1: return {m_bd, 1'b0, m_ce, 12'd0, irq_in, m_soft, 1'b0, m_code, 2'b00};
            3'd2: return m_epc;
            3'd3: return m_bva;
            3'd4: return m_ctx;
            3'd5: return m_ehi;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic ok, ent, e_dly, e_tlb, e_copu;
        logic [31:0] e_pc, e_vec, e_va;
        logic [4:0]  e_code;
        logic [1:0]  e_cop;
        if (!rst_n) begin
            m_st = 0; m_epc = 0; m_bva = 0; m_ctx = 0; m_ehi = 0; m_rpc = 0;
            m_bd = 0; m_rv = 0; m_dup = 0; m_held = 0; m_ce = 0; m_soft = 0; m_code = 0;
        end else begin
            ok  = (m_st[2:0] == 3'b001) && ((m_st[15:8] & {irq_in, m_soft}) != 0);
            ent = 0;
            e_pc = 0; e_vec = 0; e_va = 0; e_dly = 0; e_tlb = 0; e_copu = 0; e_code = 0; e_cop = 0;
            if (m_held) begin
                m_dup = exc_req;
                if (commit_pt) begin
                    ent = 1; e_pc = l_pc; e_dly = l_dly; e_code = l_code; e_vec = l_vec;
                    e_tlb = l_tlb; e_copu = l_copu; e_cop = l_cop; e_va = l_va;
                    m_held = 0;
                end
            end else begin
                m_dup = 0;
                if (exc_req) begin
                    m_held = 1; l_pc = pc_in; l_dly = pc_in_dslot; l_cop = exc_cop;
                    l_va = tlb_vaddr; l_vec = GV; l_tlb = 0; l_copu = 0;
                    if (exc_kind == 2'd0) l_code = 5'd9;
                    else if (exc_kind == 2'd1) l_code = 5'd8;
                    else if (exc_kind == 2'd2) begin l_code = 5'd11; l_copu = 1; end
                    else begin l_code = tlb_code; l_vec = tlb_vec; l_tlb = 1; end
                end else if (commit_pt && ok) begin
                    ent = 1; e_pc = pc_in; e_dly = pc_in_dslot; e_code = 0; e_vec = GV;
                end
            end
            m_rv = ent;
            if (ent) begin
                m_rpc = e_vec;
                m_st[1] = 1'b1;
                m_epc = e_dly ? e_pc - 4 : e_pc;
                m_bd = e_dly;
                m_code = e_code;
                if (e_copu) m_ce = e_cop;
                if (e_tlb) begin
                    m_bva = e_va;
                    m_ctx = (m_ctx & 32'hFF80_0000) | ((e_va >> 13) << 4);
                    m_ehi = (m_ehi & 32'h0000_1FFF) | (e_va & 32'hFFFF_E000);
                end
            end else if (cp_we) begin
                case (cp_addr)
                    3'd0: m_st = cp_wdata;
                    3'd1: m_soft = cp_wdata[9:8];
                    3'd2: m_epc = cp_wdata;
                    3'd4: m_ctx = (m_ctx & 32'h007F_FFFF) | (cp_wdata & 32'hFF80_0000);
                    3'd5: m_ehi = cp_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (started && rst_n && !done) begin
            chk({cur_tag, " redirect strobe"}, {31'd0, redir_valid}, {31'd0, m_rv});
            if (m_rv) chk({cur_tag, " redirect pc"}, redir_pc, m_rpc);
            chk({cur_tag, " duplicate flag"}, {31'd0, dup_req_err}, {31'd0, m_dup});
            chk({cur_tag, " register read"}, cp_rdata, m_read(cp_addr));
        end
    end

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        cp_addr = a;
        #1;
        chk(tag, cp_rdata, exp);
    endtask

    task automatic swr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cp_we = 1; cp_addr = a; cp_wdata = d;
        @(negedge clk);
        cp_we = 0;
    endtask

    task automatic req(input logic [1:0] k, input logic [1:0] cop, input logic [4:0] code,
                       input logic [31:0] vec, input logic [31:0] va,
                       input logic [31:0] pc, input logic dly, input logic with_commit);
        @(negedge clk);
        exc_req = 1; exc_kind = k; exc_cop = cop; tlb_code = code; tlb_vec = vec;
        tlb_vaddr = va; pc_in = pc; pc_in_dslot = dly; commit_pt = with_commit;
        @(negedge clk);
        exc_req = 0; commit_pt = 0; pc_in = 32'hDEAD_0000; pc_in_dslot = 0;
    endtask

    task automatic commit();
        @(negedge clk);
        commit_pt = 1;
        @(negedge clk);
        commit_pt = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        started = 1;
        // R14 reset values
        for (int a = 0; a < 6; a++) rd(a[2:0], 32'd0, "R14 reset value");

        // R1 R10 R11: breakpoint, captured PC used at commit
        cur_tag = "R11";
        req(2'd0, 2'd0, 5'd0, 0, 0, 32'h0000_1000, 1'b0, 1'b0);
        chk("R11 no redirect while held", {31'd0, redir_valid}, 32'd0);
        pc_in = 32'h5555_0000;
        commit();
        chk("R11 redirect after commit", {31'd0, redir_valid}, 32'd1);
        chk("R10 general vector", redir_pc, GV);
        rd(3'd0, 32'h0000_0002, "R1 EXL set");
        rd(3'd2, 32'h0000_1000, "R1 R11 EPC captured pc");
        rd(3'd1, 32'h0000_0024, "R1 BD clear code 9");

        // R2: delay slot system call
        cur_tag = "R2";
        swr(3'd0, 32'h0000_0001);
        req(2'd1, 2'd0, 5'd0, 0, 0, 32'h0000_2004, 1'b1, 1'b0);
        commit();
        rd(3'd2, 32'h0000_2000, "R2 EPC minus 4");
        rd(3'd1, 32'h8000_0020, "R2 BD set code 8");
        rd(3'd0, 32'h0000_0003, "R1 EXL after syscall");

        // R9 R3: coprocessor unusable, soft bits kept
        cur_tag = "R9";
        swr(3'd0, 32'h0000_0000);
        swr(3'd1, 32'h0000_0300);
        req(2'd2, 2'd2, 5'd0, 0, 0, 32'h0000_3000, 1'b0, 1'b0);
        commit();
        rd(3'd1, 32'h2000_032C, "R9 cop field 2");
        req(2'd2, 2'd1, 5'd0, 0, 0, 32'h0000_3010, 1'b0, 1'b0);
        commit();
        rd(3'd1, 32'h1000_032C, "R9 cop field replaced");
        cur_tag = "R3";
        req(2'd0, 2'd3, 5'd0, 0, 0, 32'h0000_3020, 1'b0, 1'b0);
        commit();
        rd(3'd1, 32'h1000_0324, "R3 only code changes");

        // R6 R7 R8 R10: translation fault
        cur_tag = "R7";
        swr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, 32'hFF80_0000, "R14 context write mask");
        swr(3'd5, 32'h1234_5ABC);
        req(2'd3, 2'd0, 5'd2, 32'h8000_0000, 32'hABCD_E123, 32'h0000_4000, 1'b0, 1'b0);
        commit();
        chk("R10 own vector", redir_pc, 32'h8000_0000);
        rd(3'd3, 32'hABCD_E123, "R6 BadVAddr");
        rd(3'd4, 32'hFFD5_E6F0, "R7 Context merge");
        rd(3'd5, 32'hABCD_FABC, "R8 EntryHi merge");
        rd(3'd1, 32'h1000_0308, "R10 TLB code 2");

        // R4 R5: interrupt gating
        cur_tag = "R4";
        swr(3'd1, 32'h0000_0000);
        irq_in = 6'b000001;
        pc_in = 32'h0000_4444;
        swr(3'd0, 32'h0000_0403);
        commit();
        chk("R4 blocked by EXL", {31'd0, redir_valid}, 32'd0);
        swr(3'd0, 32'h0000_0405);
        commit();
        chk("R4 blocked by ERL", {31'd0, redir_valid}, 32'd0);
        swr(3'd0, 32'h0000_0400);
        commit();
        chk("R4 blocked by IE clear", {31'd0, redir_valid}, 32'd0);
        cur_tag = "R5";
        swr(3'd0, 32'h0000_0801);
        commit();
        chk("R5 masked line", {31'd0, redir_valid}, 32'd0);
        swr(3'd0, 32'h0000_0401);
        pc_in = 32'h0000_4444;
        commit();
        chk("R4 taken", {31'd0, redir_valid}, 32'd1);
        chk("R10 interrupt vector", redir_pc, GV);
        rd(3'd1, 32'h1000_0400, "R4 code 0 pending shown");
        rd(3'd2, 32'h0000_4444, "R4 EPC");
        irq_in = 0;
        swr(3'd0, 32'h0000_0101);
        swr(3'd1, 32'h0000_0100);
        pc_in = 32'h0000_4480;
        commit();
        chk("R5 software bit taken", {31'd0, redir_valid}, 32'd1);

        // R12: request and interrupt in the same cycle
        cur_tag = "R12";
        swr(3'd1, 32'h0000_0000);
        irq_in = 6'b000001;
        swr(3'd0, 32'h0000_0401);
        req(2'd1, 2'd0, 5'd0, 0, 0, 32'h0000_5000, 1'b0, 1'b1);
        chk("R12 request wins", {31'd0, redir_valid}, 32'd0);
        commit();
        rd(3'd1, 32'h1000_0420, "R12 syscall code");
        rd(3'd2, 32'h0000_5000, "R12 EPC");
        irq_in = 0;

        // R13: duplicate request
        cur_tag = "R13";
        req(2'd0, 2'd0, 5'd0, 0, 0, 32'h0000_6000, 1'b0, 1'b0);
        req(2'd1, 2'd0, 5'd0, 0, 0, 32'h0000_7000, 1'b0, 1'b0);
        chk("R13 duplicate flagged", {31'd0, dup_req_err}, 32'd1);
        commit();
        rd(3'd1, 32'h1000_0024, "R13 first request kept");
        rd(3'd2, 32'h0000_6000, "R13 first pc kept");

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule